// File: doc/BRIEF.md
# ISA-Style Bus Cycle Controller

This block turns a single CPU bus request into a timed bus cycle. A region flag from the address decoder chooses the target. It is either an on-chip peripheral bus or an off-chip bus in the ISA style. The controller drives the address, write data and active-low read or write strobes. It counts wait states for the region and, on off-chip cycles, waits for the external device to signal ready.

Every cycle has three clock periods. The first is an address phase and the next two are strobe periods. On-chip cycles always end after those three periods. Off-chip cycles may stretch. They end only once the region's programmed wait count has run out and the ready input is sampled high, whichever happens later.

A debug mirror input can be set when a request is accepted. An on-chip access then also drives a matching read or write strobe on the off-chip bus in the same periods. External probes can observe it, and external ready has no effect on its timing. Completion is reported with a one-cycle pulse, and read data is held in a register.

Top module: `isa_cycle_ctl`

## Requirements
- R1: While reset is held and after it is released with no request, both off-chip strobes are high, the on-chip select is low, the write-data enable is low and the done pulse is low.
- R2: An on-chip cycle asserts the on-chip select for exactly two clock periods, the second and third after acceptance. The done pulse appears in the clock period after the third, regardless of the wait count or the ready input.
- R3: An off-chip cycle with a wait count of zero and ready high has the same three-period length as an on-chip cycle.
- R4: An off-chip cycle with a wait count of N and ready high lasts 3+N periods.
- R5: An off-chip cycle ends at the first strobe period after the second in which the wait count has expired and ready is sampled high. With N waits and ready held low for the first K+1 strobe periods, the cycle lasts 3+max(N,K) periods.
- R6: Strobes are active low. The read strobe is used only for reads and the write strobe only for writes, never both at once. The address is valid one period before a strobe falls and stays stable until the strobe rises.
- R7: Done is high for exactly one period per cycle. Read data is captured at the completion edge: from the on-chip bus for on-chip reads and from the off-chip data input otherwise. Write cycles leave the read-data register unchanged.
- R8: With the debug mirror set at acceptance, an on-chip access also drives the off-chip strobe that matches its direction, in the same two strobe periods, with the same address and write data.
- R9: With the debug mirror clear, an on-chip access leaves both off-chip strobes high.
- R10: A request is accepted only when the controller is idle. A request raised during a busy cycle produces no extra cycle and no extra done pulse.
- R11: During an off-chip or mirrored write, the write-data enable is high from the address phase to the end of the cycle, and the off-chip data output carries the request's write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_onchip | input | 1 | Decoder result: 1 = on-chip peripheral |
| req_waits | input | WSW | Programmed wait count for the region |
| dbg_mirror | input | 1 | Mirror on-chip accesses onto the off-chip bus |
| done | output | 1 | One-period completion pulse |
| rd_data | output | DW | Captured read data |
| ip_sel | output | 1 | On-chip peripheral select |
| ip_write | output | 1 | On-chip direction |
| ip_addr | output | AW | On-chip address |
| ip_wdata | output | DW | On-chip write data |
| ip_rdata | input | DW | On-chip read data |
| ext_addr | output | AW | Off-chip address |
| ext_dout | output | DW | Off-chip write data |
| ext_doe | output | 1 | Off-chip write-data enable |
| ext_din | input | DW | Off-chip read data |
| ext_rd_n | output | 1 | Off-chip read strobe, active low |
| ext_wr_n | output | 1 | Off-chip write strobe, active low |
| ext_ready | input | 1 | Off-chip ready feedback, high = ready |

## Verification
The assertions assume that the CPU side starts a request only when no earlier cycle is still waiting for its done pulse, apart from deliberate stray pulses aimed at a busy cycle. They also assume that the on-chip and off-chip read data stay stable while a strobe is low. The bench's device models derive read data from the held address, so the data cannot change within a cycle. The driver waits for each done before issuing the next request. Ready from the off-chip model depends only on how many strobe periods have elapsed, so the completion period follows from the wait count and the ready hold time.

// File: rtl/isa_cycle_ctl.sv
module isa_cycle_ctl #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int WSW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic           req_write,
  input  logic           req_onchip,
  input  logic [WSW-1:0] req_waits,
  input  logic           dbg_mirror,
  output logic           done,
  output logic [DW-1:0]  rd_data,
  output logic           ip_sel,
  output logic           ip_write,
  output logic [AW-1:0]  ip_addr,
  output logic [DW-1:0]  ip_wdata,
  input  logic [DW-1:0]  ip_rdata,
  output logic [AW-1:0]  ext_addr,
  output logic [DW-1:0]  ext_dout,
  output logic           ext_doe,
  input  logic [DW-1:0]  ext_din,
  output logic           ext_rd_n,
  output logic           ext_wr_n,
  input  logic           ext_ready
);
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_STB1, S_STB2} st_t;

  st_t            st;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic           wr_q, onchip_q, mir_q;
  logic [WSW-1:0] wcnt;

  logic accept, finish, strobing, ext_active;

  assign accept     = (st == S_IDLE) && req_valid;
  assign finish     = (st == S_STB2) && (onchip_q || (wcnt == '0 && ext_ready));
  assign strobing   = (st == S_STB1) || (st == S_STB2);
  assign ext_active = !onchip_q || mir_q;

  assign ip_sel   = strobing && onchip_q;
  assign ip_write = wr_q;
  assign ip_addr  = addr_q;
  assign ip_wdata = wdata_q;

  assign ext_addr = addr_q;
  assign ext_dout = wdata_q;
  assign ext_doe  = (st != S_IDLE) && ext_active && wr_q;
  assign ext_rd_n = !(strobing && ext_active && !wr_q);
  assign ext_wr_n = !(strobing && ext_active && wr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      wr_q     <= 1'b0;
      onchip_q <= 1'b0;
      mir_q    <= 1'b0;
      wcnt     <= '0;
      done     <= 1'b0;
      rd_data  <= '0;
    end else begin
      done <= finish;
      case (st)
        S_IDLE: if (accept) begin
          st       <= S_ADDR;
          addr_q   <= req_addr;
          wdata_q  <= req_wdata;
          wr_q     <= req_write;
          onchip_q <= req_onchip;
          mir_q    <= dbg_mirror;
          wcnt     <= req_waits;
        end
        S_ADDR: st <= S_STB1;
        S_STB1: st <= S_STB2;
        S_STB2: begin
          if (wcnt != '0) wcnt <= wcnt - 1'b1;
          if (finish) begin
            st <= S_IDLE;
            if (!wr_q) rd_data <= onchip_q ? ip_rdata : ext_din;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module isa_cycle_ctl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          ip_sel,
  input logic          mir_q,
  input logic [AW-1:0] ext_addr,
  input logic          ext_rd_n,
  input logic          ext_wr_n,
  input logic          ext_doe
);
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

  p_addr_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ext_rd_n) || $fell(ext_wr_n)) |-> $stable(ext_addr));

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ext_rd_n && $past(!ext_rd_n)) || (!ext_wr_n && $past(!ext_wr_n))) |-> $stable(ext_addr));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ip_sel || !ext_rd_n || !ext_wr_n));

  p_ip_sel_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ip_sel) |=> ip_sel ##1 !ip_sel);

  p_no_stray_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_sel && !mir_q) |-> (ext_rd_n && ext_wr_n && !ext_doe));

  p_mirror_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_sel && mir_q) |-> (!ext_rd_n || !ext_wr_n));
endmodule

bind isa_cycle_ctl isa_cycle_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .ip_sel(ip_sel), .mir_q(mir_q),
  .ext_addr(ext_addr), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_doe(ext_doe)
);

// File: tb/isa_cycle_ctl_test.sv
`timescale 1ns/1ps
module isa_cycle_ctl_test;
  localparam int AW = 16, DW = 16, WSW = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_onchip = 0, dbg_mirror = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [WSW-1:0] req_waits = '0;
  logic done, ip_sel, ip_write, ext_doe, ext_rd_n, ext_wr_n;
  logic ext_ready = 1;
  logic [DW-1:0] rd_data, ip_wdata, ip_rdata, ext_dout, ext_din;
  logic [AW-1:0] ip_addr, ext_addr;

  always #2.5 clk = ~clk;

  isa_cycle_ctl #(.AW(AW), .DW(DW), .WSW(WSW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_onchip(req_onchip),
    .req_waits(req_waits), .dbg_mirror(dbg_mirror), .done(done), .rd_data(rd_data),
    .ip_sel(ip_sel), .ip_write(ip_write), .ip_addr(ip_addr), .ip_wdata(ip_wdata),
    .ip_rdata(ip_rdata), .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
    .ext_din(ext_din), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_ready(ext_ready)
  );

  assign ip_rdata = ip_addr + 16'h1111;
  assign ext_din  = ext_addr ^ 16'h5A3C;

  typedef struct {
    logic onchip, wr, mir;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    int start, len;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0, cyc = 0, pending = 0, dones = 0, issued = 0;
  int hold_k = 0, scnt = 0;
  logic [DW-1:0] last_rd = '0;
  logic saw_ext = 0, saw_ip = 0, bad_dir = 0, bad_ext = 0, bad_ip = 0, prev_low = 0;
  logic [AW-1:0] prev_addr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // off-chip device model: ready low for the first hold_k+1 strobe periods
  always @(negedge clk) begin
    if (!ext_rd_n || !ext_wr_n) begin
      scnt = scnt + 1;
      ext_ready = (scnt > hold_k + 1);
    end else begin
      scnt = 0;
      ext_ready = (hold_k == 0);
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      logic low;
      low = !ext_rd_n || !ext_wr_n;
      if (low) begin
        saw_ext = 1;
        if (q[0].wr ? !ext_rd_n : !ext_wr_n) bad_dir = 1;
        if (ext_addr != q[0].addr) bad_ext = 1;
        if (!prev_low && ext_addr != prev_addr) bad_ext = 1;
        if (q[0].wr && (ext_dout != q[0].wdata || !ext_doe)) bad_ext = 1;
      end
      if (ip_sel) begin
        saw_ip = 1;
        if (ip_addr != q[0].addr || ip_write != q[0].wr || (q[0].wr && ip_wdata != q[0].wdata)) bad_ip = 1;
      end
      prev_low = low;
      prev_addr = ext_addr;
    end
    if (rst_n && done) begin
      dones++;
      if (q.size() == 0) begin
        chk(0, "R10", "unexpected done", 1, 0);
      end else begin
        item_t f;
        f = q.pop_front();
        chk(cyc - f.start == f.len + 1,
            f.onchip ? "R2" : (f.len > 3 ? "R5" : "R3"), "cycle length", cyc - f.start - 1, f.len);
        chk(rd_data == f.rdata, "R7", "read data", rd_data, f.rdata);
        chk(!bad_dir, "R6", "strobe direction", bad_dir, 0);
        chk(saw_ext == (!f.onchip || f.mir), f.onchip ? (f.mir ? "R8" : "R9") : "R3",
            "off-chip strobe seen", saw_ext, !f.onchip || f.mir);
        chk(!bad_ext, f.wr ? "R11" : "R6", "off-chip addr/data", bad_ext, 0);
        chk(saw_ip == f.onchip && !bad_ip, "R2", "on-chip select", saw_ip, f.onchip);
        pending--;
      end
      saw_ext = 0; saw_ip = 0; bad_dir = 0; bad_ext = 0; bad_ip = 0; prev_low = 0;
    end
  end

  task automatic access(input bit onchip, input bit wr, input bit mir, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input int waits, input int hold, input int len);
    item_t it;
    @(negedge clk);
    hold_k = hold;
    ext_ready = (hold == 0);
    req_valid = 1; req_onchip = onchip; req_write = wr; dbg_mirror = mir;
    req_addr = a; req_wdata = wd; req_waits = WSW'(waits);
    it.onchip = onchip; it.wr = wr; it.mir = mir; it.addr = a; it.wdata = wd;
    if (!wr) last_rd = onchip ? a + 16'h1111 : a ^ 16'h5A3C;
    it.rdata = last_rd; it.start = cyc; it.len = len;
    q.push_back(it);
    pending++; issued++;
    @(negedge clk);
    req_valid = 0; dbg_mirror = 0;
    while (pending != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1;
    chk(ext_rd_n && ext_wr_n && !ip_sel && !done && !ext_doe, "R1", "state in reset", {ext_rd_n, ext_wr_n}, 3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(ext_rd_n && ext_wr_n && !ip_sel && !done && !ext_doe, "R1", "idle after reset", {ext_rd_n, ext_wr_n, ip_sel, done}, 4'hC);

    access(1, 0, 0, 16'h0040, 16'h0,    7, 0, 3);  // R2 on-chip read, waits ignored
    access(1, 1, 0, 16'h0044, 16'hBEEF, 0, 3, 3);  // R2 R9 on-chip write, ready ignored
    access(0, 0, 0, 16'h8000, 16'h0,    0, 0, 3);  // R3
    access(0, 1, 0, 16'h8002, 16'hCAFE, 0, 0, 3);  // R3 R11
    access(0, 0, 0, 16'h8010, 16'h0,    4, 0, 7);  // R4
    access(0, 1, 0, 16'h8012, 16'h1234, 2, 0, 5);  // R4 R11
    access(0, 0, 0, 16'h8020, 16'h0,    0, 3, 6);  // R5 ready alone
    access(0, 0, 0, 16'h8024, 16'h0,    5, 2, 8);  // R5 count later
    access(0, 1, 0, 16'h8028, 16'h5555, 1, 4, 7);  // R5 ready later
    access(1, 0, 1, 16'h0050, 16'h0,    0, 2, 3);  // R8 mirrored read
    access(1, 1, 1, 16'h0054, 16'hA0A0, 0, 0, 3);  // R8 R11 mirrored write
    access(1, 0, 0, 16'h0058, 16'h0,    0, 0, 3);  // R9

    // R10: stray request during a busy cycle
    fork
      access(0, 0, 0, 16'h9000, 16'h0, 6, 0, 9);
      begin
        repeat (3) @(negedge clk);
        req_valid = 1; req_addr = 16'h7777; req_onchip = 1;
        @(negedge clk);
        req_valid = 0;
      end
    join
    repeat (12) @(negedge clk);
    chk(dones == issued, "R10", "done count", dones, issued);
    chk(ext_rd_n && ext_wr_n && !ip_sel, "R10", "no extra cycle", {ext_rd_n, ext_wr_n, ip_sel}, 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule